// File: doc/BRIEF.md
# Stacked Interrupt Priority Controller

This block keeps the processor's running interrupt level together with a short history of earlier levels. The history sits in one byte split into four 2-bit slots. The low slot is the level in force now. Each higher slot holds an older level, so the byte works as a small hardware stack.

Up to `N_SRC` sources raise requests. Each source has its own enable bit and its own 2-bit level. The block picks one winner from the enabled, requesting sources. It flags that winner to the processor only when the winner's level is strictly above the current level. When the processor confirms entry, the winner's level is pushed. The pipeline may also push an explicit level, pop back to the previous level, or overwrite the whole byte. The byte is always visible, so software can spill it to memory and reload it when nesting goes deeper than four levels.

Top module: `ipl_stack_ctrl`

## Requirements
- R1: After reset, `stack_o` is 0x00 and `irq_o` is low.
- R2: `irq_o` is high only when at least one source has both its request and its enable bit set and a level strictly greater than `cur_lvl_o`. A disabled source, or a source at the same or a lower level, never raises it. Source i's level is `prio_i[2*i+1:2*i]`.
- R3: Among eligible sources, the one with the highest level is reported on `irq_id_o` and `irq_lvl_o`. On a level tie, the lowest source index wins.
- R4: `enter_i` while `irq_o` is high makes the next `stack_o` equal to the old value shifted left by two, with `irq_lvl_o` in bits 1:0. `enter_i` while `irq_o` is low changes nothing.
- R5: `set_i` pushes `set_lvl_i` with the same left shift into bits 1:0.
- R6: `restore_i` shifts `stack_o` right by two and puts zeros into bits 7:6.
- R7: Only four levels are kept. A fifth push loses the value that was in bits 7:6.
- R8: `load_i` writes `load_val_i` into all eight bits. `stack_o` shows all eight bits, and `cur_lvl_o` equals bits 1:0.
- R9: When commands arrive in the same cycle, the order is: load first, then interrupt entry, then set, then restore. Only the winning command takes effect.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| req_i | input | N_SRC | Request line per source |
| en_i | input | N_SRC | Enable bit per source |
| prio_i | input | 2*N_SRC | Level per source, 2 bits each, source 0 lowest |
| enter_i | input | 1 | Processor takes the flagged interrupt |
| set_i | input | 1 | Push an explicit level |
| set_lvl_i | input | 2 | Level pushed by `set_i` |
| restore_i | input | 1 | Pop back to the previous level |
| load_i | input | 1 | Overwrite the whole stack byte |
| load_val_i | input | 8 | Value written by `load_i` |
| irq_o | output | 1 | An eligible request beats the current level |
| irq_id_o | output | clog2(N_SRC) | Index of the winning source |
| irq_lvl_o | output | 2 | Level of the winning source |
| stack_o | output | 8 | Whole stack byte |
| cur_lvl_o | output | 2 | Current level (bits 1:0) |

## Verification
The risky overlap is interrupt entry landing in the same cycle as another stack command. The case that matters most is a full-register load that arrives just as a winning request is being taken; entry against an explicit set, and entry against a restore, are the other two. The bench raises an eligible request, confirms that `irq_o` is high, and in that same cycle asserts `enter_i` together with the competing command. It then reads `stack_o` one edge later. Only the value given by the precedence order in R9 counts as correct.

// File: rtl/ipl_pkg.sv
package ipl_pkg;

  // Stack operation chosen for one cycle, after precedence is resolved
  typedef enum logic [2:0] {
    IPL_HOLD  = 3'd0,
    IPL_LOAD  = 3'd1,
    IPL_ENTER = 3'd2,
    IPL_SET   = 3'd3,
    IPL_POP   = 3'd4
  } ipl_op_e;

endpackage

// File: rtl/ipl_arbiter.sv
module ipl_arbiter #(
  parameter int N_SRC = 8,
  parameter int LVL_W = 2,
  localparam int ID_W = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC-1:0]       en_i,
  input  logic [N_SRC*LVL_W-1:0] prio_i,
  input  logic [LVL_W-1:0]       cur_lvl_i,
  output logic                   hit_o,
  output logic [ID_W-1:0]        id_o,
  output logic [LVL_W-1:0]       lvl_o,
  output logic [N_SRC-1:0]       grant_o
);

  // A source may compete only if it requests, is enabled, and beats the current level
  logic [N_SRC-1:0] elig;

  genvar g;
  generate
    for (g = 0; g < N_SRC; g++) begin : g_elig
      assign elig[g] = req_i[g] & en_i[g] &
                       (prio_i[g*LVL_W +: LVL_W] > cur_lvl_i);
    end
  endgenerate

  // Scan upward and replace the holder only on a strictly higher level,
  // so the lowest index keeps a tie
  always_comb begin
    hit_o = 1'b0;
    id_o  = '0;
    lvl_o = '0;
    for (int i = 0; i < N_SRC; i++) begin
      if (elig[i] && (!hit_o || (prio_i[i*LVL_W +: LVL_W] > lvl_o))) begin
        hit_o = 1'b1;
        id_o  = ID_W'(i);
        lvl_o = prio_i[i*LVL_W +: LVL_W];
      end
    end
  end

  always_comb begin
    grant_o = '0;
    if (hit_o) grant_o[id_o] = 1'b1;
  end

endmodule

// File: rtl/ipl_stack_reg.sv
module ipl_stack_reg
  import ipl_pkg::*;
#(
  parameter int LVL_W = 2,
  parameter int DEPTH = 4,
  localparam int STK_W = LVL_W * DEPTH
) (
  input  logic             clk,
  input  logic             rst_n,
  input  ipl_op_e          op_i,
  input  logic [LVL_W-1:0] push_lvl_i,
  input  logic [STK_W-1:0] load_val_i,
  output logic [STK_W-1:0] stk_o
);

  // Push: drop the oldest slot, new level lands in the low slot
  function automatic logic [STK_W-1:0] stk_push(input logic [STK_W-1:0] s,
                                                input logic [LVL_W-1:0] l);
    return {s[STK_W-LVL_W-1:0], l};
  endfunction

  // Pop: move every slot down one, clear the top slot
  function automatic logic [STK_W-1:0] stk_pop(input logic [STK_W-1:0] s);
    return {{LVL_W{1'b0}}, s[STK_W-1:LVL_W]};
  endfunction

  logic [STK_W-1:0] stk_q, stk_d;

  always_comb begin
    unique case (op_i)
      IPL_LOAD:            stk_d = load_val_i;
      IPL_ENTER, IPL_SET:  stk_d = stk_push(stk_q, push_lvl_i);
      IPL_POP:             stk_d = stk_pop(stk_q);
      default:             stk_d = stk_q;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) stk_q <= '0;
    else        stk_q <= stk_d;
  end

  assign stk_o = stk_q;

  // A pop leaves the top slot empty and the older slots moved down
  assert_pop_fill_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == IPL_POP) |=>
      (stk_q[STK_W-1 -: LVL_W] == '0) &&
      (stk_q[STK_W-LVL_W-1:0] == $past(stk_q[STK_W-1:LVL_W])));

  // A push keeps the three newest slots and loses the oldest
  assert_push_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (op_i == IPL_SET) |=>
      (stk_q[STK_W-1:LVL_W] == $past(stk_q[STK_W-LVL_W-1:0])));

endmodule

// File: rtl/ipl_stack_ctrl.sv
module ipl_stack_ctrl
  import ipl_pkg::*;
#(
  parameter int N_SRC = 8,
  parameter int LVL_W = 2,
  parameter int DEPTH = 4,
  localparam int STK_W = LVL_W * DEPTH,
  localparam int ID_W  = (N_SRC > 1) ? $clog2(N_SRC) : 1
) (
  input  logic                   clk,
  input  logic                   rst_n,
  input  logic [N_SRC-1:0]       req_i,
  input  logic [N_SRC-1:0]       en_i,
  input  logic [N_SRC*LVL_W-1:0] prio_i,
  input  logic                   enter_i,
  input  logic                   set_i,
  input  logic [LVL_W-1:0]       set_lvl_i,
  input  logic                   restore_i,
  input  logic                   load_i,
  input  logic [STK_W-1:0]       load_val_i,
  output logic                   irq_o,
  output logic [ID_W-1:0]        irq_id_o,
  output logic [LVL_W-1:0]       irq_lvl_o,
  output logic [STK_W-1:0]       stack_o,
  output logic [LVL_W-1:0]       cur_lvl_o
);

  logic [N_SRC-1:0] grant;
  logic             take_evt;   // entry accepted this cycle
  ipl_op_e          op;
  logic [LVL_W-1:0] push_lvl;

  ipl_arbiter #(.N_SRC(N_SRC), .LVL_W(LVL_W)) u_arb (
    .req_i     (req_i),
    .en_i      (en_i),
    .prio_i    (prio_i),
    .cur_lvl_i (cur_lvl_o),
    .hit_o     (irq_o),
    .id_o      (irq_id_o),
    .lvl_o     (irq_lvl_o),
    .grant_o   (grant)
  );

  assign take_evt = enter_i & irq_o;

  // Precedence: load, then entry, then set, then restore
  always_comb begin
    if (load_i)         op = IPL_LOAD;
    else if (take_evt)  op = IPL_ENTER;
    else if (set_i)     op = IPL_SET;
    else if (restore_i) op = IPL_POP;
    else                op = IPL_HOLD;
  end

  assign push_lvl = take_evt ? irq_lvl_o : set_lvl_i;

  ipl_stack_reg #(.LVL_W(LVL_W), .DEPTH(DEPTH)) u_stk (
    .clk        (clk),
    .rst_n      (rst_n),
    .op_i       (op),
    .push_lvl_i (push_lvl),
    .load_val_i (load_val_i),
    .stk_o      (stack_o)
  );

  assign cur_lvl_o = stack_o[LVL_W-1:0];

  // The flagged level must beat the level held in the stack
  assert_beats_current_R2: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> (irq_lvl_o > cur_lvl_o));

  // The reported source must be requesting and enabled, with a single grant
  assert_grant_valid_R3: assert property (@(posedge clk) disable iff (!rst_n)
    irq_o |-> ($onehot(grant) && req_i[irq_id_o] && en_i[irq_id_o]));

  // Taking an interrupt makes its level the current one
  assert_enter_push_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (enter_i && irq_o && !load_i) |=> (cur_lvl_o == $past(irq_lvl_o)));

  // A load overrides every other command
  assert_load_wins_R9: assert property (@(posedge clk) disable iff (!rst_n)
    load_i |=> (stack_o == $past(load_val_i)));

endmodule

// File: tb/sim_ipl_stack_ctrl.sv
module sim_ipl_stack_ctrl;

  localparam int N_SRC = 8;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic [7:0]  req_i = '0, en_i = '0;
  logic [15:0] prio_i = '0;
  logic        enter_i = 1'b0, set_i = 1'b0, restore_i = 1'b0, load_i = 1'b0;
  logic [1:0]  set_lvl_i = '0;
  logic [7:0]  load_val_i = '0;
  logic        irq_o;
  logic [2:0]  irq_id_o;
  logic [1:0]  irq_lvl_o;
  logic [7:0]  stack_o;
  logic [1:0]  cur_lvl_o;

  int n_chk = 0, n_fail = 0;

  always #2.5 clk = ~clk;

  ipl_stack_ctrl #(.N_SRC(N_SRC)) u0 (
    .clk(clk), .rst_n(rst_n), .req_i(req_i), .en_i(en_i), .prio_i(prio_i),
    .enter_i(enter_i), .set_i(set_i), .set_lvl_i(set_lvl_i),
    .restore_i(restore_i), .load_i(load_i), .load_val_i(load_val_i),
    .irq_o(irq_o), .irq_id_o(irq_id_o), .irq_lvl_o(irq_lvl_o),
    .stack_o(stack_o), .cur_lvl_o(cur_lvl_o)
  );

  typedef struct packed {
    logic        ld;
    logic [7:0]  ld_val;
    logic [7:0]  req;
    logic [7:0]  en;
    logic [15:0] prio;
    logic        ent;
    logic        st;
    logic [1:0]  st_lvl;
    logic        rs;
    logic        x_irq;
    logic [2:0]  x_id;
    logic [1:0]  x_lvl;
    logic [7:0]  x_stk;
  } vec_t;

  localparam int NV = 17;
  //                 ld  ldval  req    en     prio      ent   st  sl    rs   irq  id    lvl   stk
  localparam vec_t VT [NV] = '{
    '{1'b0,8'h00,8'h01,8'h01,16'h0001,1'b1,1'b0,2'd0,1'b0,1'b1,3'd0,2'd1,8'h01}, // R4 take src0
    '{1'b0,8'h00,8'h02,8'h02,16'h0004,1'b1,1'b0,2'd0,1'b0,1'b0,3'd0,2'd0,8'h01}, // R2 equal level blocked
    '{1'b0,8'h00,8'h0C,8'h0C,16'h00F0,1'b0,1'b0,2'd0,1'b0,1'b1,3'd2,2'd3,8'h01}, // R3 tie -> src2
    '{1'b0,8'h00,8'hFF,8'h7F,16'hC008,1'b1,1'b0,2'd0,1'b0,1'b1,3'd1,2'd2,8'h06}, // R2 src7 disabled
    '{1'b0,8'h00,8'h00,8'h00,16'h0000,1'b0,1'b1,2'd3,1'b0,1'b0,3'd0,2'd0,8'h1B}, // R5 set 3
    '{1'b0,8'h00,8'h00,8'h00,16'h0000,1'b0,1'b1,2'd2,1'b0,1'b0,3'd0,2'd0,8'h6E}, // R5 set 2
    '{1'b0,8'h00,8'h00,8'h00,16'h0000,1'b0,1'b1,2'd1,1'b0,1'b0,3'd0,2'd0,8'hB9}, // R7 fifth push
    '{1'b0,8'h00,8'h00,8'h00,16'h0000,1'b0,1'b0,2'd0,1'b1,1'b0,3'd0,2'd0,8'h2E}, // R6 pop
    '{1'b0,8'h00,8'h00,8'h00,16'h0000,1'b0,1'b0,2'd0,1'b1,1'b0,3'd0,2'd0,8'h0B}, // R6 pop
    '{1'b0,8'h00,8'hFF,8'hFF,16'hFFFF,1'b1,1'b0,2'd0,1'b0,1'b0,3'd0,2'd0,8'h0B}, // R4 no take at top
    '{1'b0,8'h00,8'h00,8'h00,16'h0000,1'b0,1'b1,2'd1,1'b1,1'b0,3'd0,2'd0,8'h2D}, // R9 set beats pop
    '{1'b1,8'h80,8'h01,8'h01,16'h0003,1'b1,1'b0,2'd0,1'b0,1'b1,3'd0,2'd3,8'h80}, // R9 load beats entry
    '{1'b0,8'h00,8'h10,8'h10,16'h0200,1'b1,1'b1,2'd2,1'b0,1'b1,3'd4,2'd2,8'h02}, // R9 entry beats set
    '{1'b0,8'h00,8'h20,8'h20,16'h0C00,1'b1,1'b0,2'd0,1'b1,1'b1,3'd5,2'd3,8'h0B}, // R9 entry beats pop
    '{1'b0,8'h00,8'h00,8'h00,16'h0000,1'b0,1'b0,2'd0,1'b1,1'b0,3'd0,2'd0,8'h02}, // R6 pop
    '{1'b0,8'h00,8'h00,8'h00,16'h0000,1'b0,1'b0,2'd0,1'b1,1'b0,3'd0,2'd0,8'h00}, // R6 pop
    '{1'b0,8'h00,8'h00,8'h00,16'h0000,1'b0,1'b0,2'd0,1'b1,1'b0,3'd0,2'd0,8'h00}  // R6 pop on empty
  };

  task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_fail++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  task automatic idle();
    req_i = '0; en_i = '0; prio_i = '0; enter_i = 1'b0; set_i = 1'b0;
    set_lvl_i = '0; restore_i = 1'b0; load_i = 1'b0; load_val_i = '0;
  endtask

  bit done = 1'b0;

  initial begin
    #(200000 * 5);
    if (!done) begin
      n_chk++; n_fail++;
      $display("FAIL watchdog: actual running expected finished");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1: reset state
    chk("R1 stack after reset", stack_o, 8'h00);
    chk("R1 irq after reset", {7'd0, irq_o}, 8'h00);
    rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stack held", stack_o, 8'h00);

    for (int k = 0; k < NV; k++) begin
      @(negedge clk);
      load_i = VT[k].ld; load_val_i = VT[k].ld_val;
      req_i = VT[k].req; en_i = VT[k].en; prio_i = VT[k].prio;
      enter_i = VT[k].ent; set_i = VT[k].st; set_lvl_i = VT[k].st_lvl;
      restore_i = VT[k].rs;
      #1;
      chk($sformatf("R2 irq vec %0d", k), {7'd0, irq_o}, {7'd0, VT[k].x_irq});
      if (VT[k].x_irq) begin
        chk($sformatf("R3 id vec %0d", k), {5'd0, irq_id_o}, {5'd0, VT[k].x_id});
        chk($sformatf("R3 lvl vec %0d", k), {6'd0, irq_lvl_o}, {6'd0, VT[k].x_lvl});
      end
      @(posedge clk); #1;
      chk($sformatf("R4-stack vec %0d", k), stack_o, VT[k].x_stk);
      chk($sformatf("R8 cur vec %0d", k), {6'd0, cur_lvl_o}, {6'd0, VT[k].x_stk[1:0]});
    end

    // R8: full load and readout, then current level reflects the low slot
    @(negedge clk); idle(); load_i = 1'b1; load_val_i = 8'hE4;
    @(posedge clk); #1;
    chk("R8 load readout", stack_o, 8'hE4);
    chk("R8 current from load", {6'd0, cur_lvl_o}, 8'h00);

    // R2: level-3 source disabled while current is 0 -> no irq
    @(negedge clk); idle(); req_i = 8'h08; en_i = 8'h00; prio_i = 16'h00C0; enter_i = 1'b1;
    #1 chk("R2 disabled source ignored", {7'd0, irq_o}, 8'h00);
    @(posedge clk); #1;
    chk("R2 stack untouched", stack_o, 8'hE4);

    // R1: mid-run reset clears the stack
    @(negedge clk); idle(); rst_n = 1'b0;
    #1 chk("R1 async reset", stack_o, 8'h00);
    @(negedge clk); rst_n = 1'b1;
    @(negedge clk);
    chk("R1 stays clear", stack_o, 8'h00);

    done = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end

endmodule